// File: doc/BRIEF.md
# AFSK Bit Demodulator with Phase-Tracked Bit Clock

This block turns a stream of signed 8-bit audio samples, arriving at 9600 samples per second, into data bits of a 1200 bit/s two-tone audio link. Tone discrimination multiplies each new sample by the one taken half a bit (four samples) before it. A first-order low-pass recursion built from shifts and adds smooths the product, and a sign slicer reduces the result to one level per sample.

A phase counter gives the bit clock. It advances a fixed step for every accepted sample. Whenever the slicer level changes, the counter is pulled by one unit toward the nearer bit boundary. When the counter wraps, the block decides the bit from a majority of the last three slicer levels. It then removes the line's transition coding by comparing that decision with the one before it. The recovered bit leaves the block with a one-cycle strobe. Samples are accepted only in cycles where the sample-valid input is high. A deframer downstream consumes the bits.

Top module: `afsk_demod`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the bit strobe is low. Reset clears the four-sample delay line, the filter state, the level history, the phase counter and the decision history to zero.
- R2: When the slicer shows no level change, the strobe rises once every 8 accepted samples. It is high for exactly one cycle, in the cycle after the sample that completed the bit.
- R3: A cycle with sample-valid low changes no state and never raises the strobe. Bit cadence counts accepted samples only.
- R4: The discriminator value for a sample is that sample times the sample accepted four samples earlier, arithmetically shifted right by 2. Before four samples have arrived, the earlier sample counts as zero.
- R5: The filter output is the previous and current discriminator values plus the previous output shifted right arithmetically by 1, by 3 and by 5. It is kept in a signed 16-bit register.
- R6: The slicer level is 1 only when the new filter output is strictly greater than zero. A zero output gives 0.
- R7: The phase counter runs from 0 to 63 and gains 8 per accepted sample. On a slicer level change it first gains 1 if it is below 32, and otherwise loses 1. On reaching 64 or more it drops by 64 and a bit is decided.
- R8: The decided bit is 1 when at least two of the three newest slicer levels are 1.
- R9: The output bit is 1 when the new decision equals the previous decision, and 0 when they differ. The decision history starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | The sample on smp_in is accepted in this cycle |
| smp_in | input | 8 | Signed audio sample |
| bit_stb | output | 1 | One-cycle strobe: a recovered bit is on bit_val |
| bit_val | output | 1 | Recovered data bit, held between strobes |

## Verification
A wrong delay tap, filter term or slicer threshold changes the slicer level within a few samples. That error reaches the ports as a moved strobe or a flipped bit at the next bit decision, at most about nine samples later. Phase-counter faults show up as strobes whose spacing is not eight accepted samples, or that shift after a level change. Wrong majority or transition decoding flips the bit in the very strobe where the error occurs. The bench therefore compares every strobe and bit against an independent sample-by-sample model, over tone bursts of several amplitudes and timing slips. Hand-worked sequences pin down the first strobe position and values.

// File: rtl/afsk_demod_pkg.sv
package afsk_demod_pkg;

    localparam int SMP_W     = 8;
    localparam int ACC_W     = 16;
    localparam int SPB       = 8;
    localparam int DLY_LEN   = SPB / 2;
    localparam int PROD_SHR  = 2;
    localparam int PH_STEP   = 8;
    localparam int PH_NUDGE  = 1;
    localparam int PH_FULL   = SPB * PH_STEP;
    localparam int PH_HALF   = PH_FULL / 2;
    localparam int PH_W      = $clog2(PH_FULL) + 1;

    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic valid;
        logic level;
    } slice_t;

    typedef struct packed {
        logic strobe;
        logic data;
    } dbit_t;

    function automatic logic vote3(input logic [2:0] b);
        return (b[0] & b[1]) | (b[0] & b[2]) | (b[1] & b[2]);
    endfunction

endpackage

// File: rtl/afsk_discrim.sv
module afsk_discrim
    import afsk_demod_pkg::*;
#(
    parameter int W   = SMP_W,
    parameter int DLY = DLY_LEN,
    parameter int SHR = PROD_SHR
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_smp,
    output acc_t                x_out
);

    localparam int PW = 2 * W;

    logic signed [W-1:0]  dly_q [DLY];
    logic signed [PW-1:0] prod;

    assign prod  = dly_q[DLY-1] * in_smp;
    assign x_out = ACC_W'(prod >>> SHR);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DLY; i++) dly_q[i] <= '0;
        end else if (in_valid) begin
            dly_q[0] <= in_smp;
            for (int i = 1; i < DLY; i++) dly_q[i] <= dly_q[i-1];
        end
    end

endmodule

// File: rtl/afsk_lpf.sv
module afsk_lpf
    import afsk_demod_pkg::*;
#(
    parameter int GUARD = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  acc_t   x_in,
    output slice_t slc,
    output acc_t   y_out
);

    localparam int SW = ACC_W + GUARD;

    acc_t                 x_prev_q;
    acc_t                 y_q;
    logic signed [SW-1:0] sum;
    acc_t                 y_nx;

    assign sum = SW'(x_prev_q) + SW'(x_in)
               + SW'(y_q >>> 1) + SW'(y_q >>> 3) + SW'(y_q >>> 5);
    assign y_nx = ACC_W'(sum);

    assign slc.valid = in_valid;
    assign slc.level = (y_nx > 0);
    assign y_out     = y_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_prev_q <= '0;
            y_q      <= '0;
        end else if (in_valid) begin
            x_prev_q <= x_in;
            y_q      <= y_nx;
        end
    end

endmodule

// File: rtl/afsk_bitsync.sv
module afsk_bitsync
    import afsk_demod_pkg::*;
#(
    parameter int FULL  = PH_FULL,
    parameter int HALF  = PH_HALF,
    parameter int STEP  = PH_STEP,
    parameter int NUDGE = PH_NUDGE,
    parameter int W     = PH_W
) (
    input  logic         clk,
    input  logic         rst,
    input  slice_t       slc,
    output dbit_t        dbit,
    output logic [W-1:0] phase
);

    logic [2:0]   hist_q, hist_n;
    logic [1:0]   found_q, found_n;
    logic [W-1:0] ph_q, ph_a, ph_b, ph_n;
    logic         lvl_edge, wrap;
    dbit_t        out_q;

    always_comb begin
        hist_n   = {hist_q[1:0], slc.level};
        lvl_edge = hist_n[0] ^ hist_n[1];
        if (!lvl_edge)
            ph_a = ph_q;
        else if (ph_q < W'(HALF))
            ph_a = ph_q + W'(NUDGE);
        else
            ph_a = ph_q - W'(NUDGE);
        ph_b    = ph_a + W'(STEP);
        wrap    = (ph_b >= W'(FULL));
        ph_n    = wrap ? (ph_b - W'(FULL)) : ph_b;
        found_n = {found_q[0], vote3(hist_n)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= '0;
            found_q <= '0;
            ph_q    <= '0;
            out_q   <= '0;
        end else begin
            out_q.strobe <= 1'b0;
            if (slc.valid) begin
                hist_q <= hist_n;
                ph_q   <= ph_n;
                if (wrap) begin
                    found_q      <= found_n;
                    out_q.strobe <= 1'b1;
                    out_q.data   <= ~(found_n[1] ^ found_n[0]);
                end
            end
        end
    end

    assign dbit  = out_q;
    assign phase = ph_q;

endmodule

// File: rtl/afsk_demod.sv
module afsk_demod
    import afsk_demod_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_in,
    output logic                    bit_stb,
    output logic                    bit_val
);

    acc_t            x_cur;
    acc_t            y_cur;
    slice_t          slc;
    dbit_t           dbit;
    logic [PH_W-1:0] phase;

    afsk_discrim #(.W(SMP_W), .DLY(DLY_LEN), .SHR(PROD_SHR)) u_disc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (smp_valid),
        .in_smp   (smp_in),
        .x_out    (x_cur)
    );

    afsk_lpf #(.GUARD(2)) u_lpf (
        .clk      (clk),
        .rst      (rst),
        .in_valid (smp_valid),
        .x_in     (x_cur),
        .slc      (slc),
        .y_out    (y_cur)
    );

    afsk_bitsync #(
        .FULL(PH_FULL), .HALF(PH_HALF), .STEP(PH_STEP),
        .NUDGE(PH_NUDGE), .W(PH_W)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .slc   (slc),
        .dbit  (dbit),
        .phase (phase)
    );

    assign bit_stb = dbit.strobe;
    assign bit_val = dbit.data;

endmodule

// File: rtl/afsk_demod_chk.sv
module afsk_demod_chk
    import afsk_demod_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            smp_valid,
    input acc_t            x_cur,
    input acc_t            y_cur,
    input logic [PH_W-1:0] phase,
    input logic            bit_stb
);

    AST_PRODUCT_SPAN: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> (x_cur >= -16'sd4096 && x_cur <= 16'sd4096)); // R4

    AST_FILTER_HEADROOM: assert property (@(posedge clk) disable iff (rst)
        (y_cur >= -16'sd24000 && y_cur <= 16'sd24000)); // R5

    AST_PHASE_BELOW_FULL: assert property (@(posedge clk) disable iff (rst)
        phase < PH_W'(PH_FULL)); // R7

    AST_IDLE_HOLDS_PHASE: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(phase)); // R3

    AST_STROBE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> $past(smp_valid)); // R3

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb); // R2

endmodule

bind afsk_demod afsk_demod_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .x_cur     (x_cur),
    .y_cur     (y_cur),
    .phase     (phase),
    .bit_stb   (bit_stb)
);

// File: tb/test_afsk_demod.sv
module test_afsk_demod;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_valid = 1'b0;
    logic signed [7:0] smp_in = '0;
    logic              bit_stb;
    logic              bit_val;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    afsk_demod i_afsk_demod (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_in    (smp_in),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val)
    );

    // stimulus table: [23:16] data byte, [15:8] amplitude, [7:0] slip samples
    localparam logic [23:0] SEG [8] = '{
        {8'h7E, 8'd100, 8'd0}, {8'h7E, 8'd100, 8'd0},
        {8'hA5, 8'd100, 8'd3}, {8'h00, 8'd90,  8'd0},
        {8'hFF, 8'd120, 8'd5}, {8'h3C, 8'd60,  8'd1},
        {8'h55, 8'd127, 8'd2}, {8'h81, 8'd40,  8'd7}
    };

    // reference model state
    int m_dly [4];
    int m_xp, m_y, m_h, m_ph, m_f;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_dly[i] = 0;
        m_xp = 0; m_y = 0; m_h = 0; m_ph = 0; m_f = 0;
    endtask

    task automatic model_step(input int s, output bit e_stb, output bit e_bit);
        int d, x, y, lvl, edg;
        d = m_dly[3];
        for (int i = 3; i > 0; i--) m_dly[i] = m_dly[i-1];
        m_dly[0] = s;
        x = (d * s) >>> 2;
        y = m_xp + x + (m_y >>> 1) + (m_y >>> 3) + (m_y >>> 5);
        m_xp = x;
        m_y  = y;
        lvl  = (y > 0) ? 1 : 0;
        m_h  = ((m_h << 1) | lvl) & 7;
        edg  = (m_h ^ (m_h >> 1)) & 1;
        if (edg != 0) m_ph = (m_ph < 32) ? m_ph + 1 : m_ph - 1;
        m_ph = m_ph + 8;
        e_stb = 1'b0;
        e_bit = 1'b0;
        if (m_ph >= 64) begin
            m_ph = m_ph - 64;
            m_f  = ((m_f << 1) | (($countones(m_h[2:0]) >= 2) ? 1 : 0)) & 3;
            e_stb = 1'b1;
            e_bit = (((m_f >> 1) & 1) == (m_f & 1));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_valid = 1'b0; smp_in = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // drive one cycle, compare against model; returns observed outputs
    task automatic push(input int s, input bit v, output bit got_stb, output bit got_bit);
        bit e_stb, e_bit;
        @(negedge clk);
        smp_valid = v;
        smp_in    = 8'(s);
        e_stb = 1'b0; e_bit = 1'b0;
        if (v) model_step(s, e_stb, e_bit);
        @(posedge clk);
        #2;
        got_stb = bit_stb;
        got_bit = bit_val;
        if (e_stb || got_stb)
            check(got_stb == e_stb && (!e_stb || got_bit == e_bit),
                  "R5 R8 R9 model strobe/bit", {got_stb, got_bit}, {e_stb, e_bit});
    endtask

    initial begin
        #(200000 * 20);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        bit gs, gb;
        int first_idx, nstb, idle_stb;
        real tph;
        int tone;

        // R1: reset state
        do_reset();
        #2;
        check(bit_stb == 1'b0, "R1 strobe low after reset", bit_stb, 0);

        // R2 R9: zero input gives a strobe on every 8th sample, bit 1
        do_reset();
        nstb = 0; first_idx = -1;
        for (int i = 1; i <= 24; i++) begin
            push(0, 1'b1, gs, gb);
            if (gs) begin
                nstb++;
                check(i % 8 == 0, "R2 strobe position", i, ((i + 7) / 8) * 8);
                check(gb == 1'b1, "R9 repeated decision gives 1", gb, 1);
            end
        end
        check(nstb == 3, "R2 strobe count over 24 samples", nstb, 3);

        // R3: idle cycles between samples change nothing
        do_reset();
        nstb = 0; idle_stb = 0; first_idx = -1;
        for (int i = 1; i <= 8; i++) begin
            push(0, 1'b1, gs, gb);
            if (gs) begin nstb++; first_idx = i; end
            for (int k = 0; k < 3; k++) begin
                push(77, 1'b0, gs, gb);
                if (gs) idle_stb++;
            end
        end
        check(idle_stb == 0, "R3 no strobe in idle cycles", idle_stb, 0);
        check(first_idx == 8, "R3 cadence counts accepted samples", first_idx, 8);

        // R4 R6 R7 R8 R9: constant input, level rises at 5th sample with phase 32
        do_reset();
        first_idx = -1; nstb = 0;
        for (int i = 1; i <= 17; i++) begin
            push(100, 1'b1, gs, gb);
            if (gs) begin
                nstb++;
                if (nstb == 1) begin
                    check(i == 9, "R7 first strobe after nudge at 9th sample", i, 9);
                    check(gb == 1'b0, "R9 decision change gives 0", gb, 0);
                end else begin
                    check(i == 17, "R7 second strobe at 17th sample", i, 17);
                    check(gb == 1'b1, "R8 majority of ones repeated gives 1", gb, 1);
                end
            end
        end
        check(nstb == 2, "R4 R6 strobe count for constant input", nstb, 2);

        // negative constant: product still positive (R4)
        do_reset();
        first_idx = -1;
        for (int i = 1; i <= 9; i++) begin
            push(-100, 1'b1, gs, gb);
            if (gs && first_idx < 0) first_idx = i;
        end
        check(first_idx == 9, "R4 negative samples give positive product", first_idx, 9);

        // table walk: two-tone bursts against the model
        do_reset();
        tph = 0.0;
        tone = 0;
        for (int sg = 0; sg < 8; sg++) begin
            for (int k = 0; k < int'(SEG[sg][7:0]); k++) begin
                push($rtoi($floor(real'(SEG[sg][15:8]) * $sin(tph) + 0.5)), 1'b1, gs, gb);
                tph = tph + 6.283185307179586 * ((tone != 0) ? 2200.0 : 1200.0) / 9600.0;
            end
            for (int b = 0; b < 8; b++) begin
                if (SEG[sg][16 + b] == 1'b0) tone = 1 - tone;
                for (int k = 0; k < 8; k++) begin
                    push($rtoi($floor(real'(SEG[sg][15:8]) * $sin(tph) + 0.5)), 1'b1, gs, gb);
                    tph = tph + 6.283185307179586 * ((tone != 0) ? 2200.0 : 1200.0) / 9600.0;
                end
                if (sg == 3 && b == 3) begin
                    push(0, 1'b0, gs, gb);
                    check(gs == 1'b0, "R3 idle mid-burst", gs, 0);
                end
            end
        end

        @(negedge clk);
        smp_valid = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule